// File: doc/BRIEF.md
# Port-Filtered Spike Address Mapper

This block sits behind a UDP receive path that has already removed the network headers. It sees the payload one byte per handshake. Each byte comes with the frame's destination port and a flag that marks the final byte. The block keeps only frames sent to one configured port. It cuts their payload into 32-bit event words, first byte most significant, and looks up each word in a runtime-writable mapping table. The result is a 14-bit local target address, which leaves the block as a spike event on a valid/ready stream.

The 16-bit source identifier sits in bits 31:16 of a word. Its low six bits index the table. The 14-bit neuron number sits in bits 13:0 and is checked against a per-entry limit. Bits 15:14 are padding. A word that misses in the table is dropped and counted. A word past the frame's word budget is also dropped and counted. The drop count is exposed as a saturating counter. Software or a neighbouring block fills the table through a one-entry-per-cycle write port.

Top module: `udp_spike_mapper`

## Requirements
- R1: After reset, `ev_valid` is 0, `drop_count` is 0, `in_ready` is 1, and every table entry is invalid, so any word is dropped until an entry is written.
- R2: The port of a frame is taken on its first byte. A frame whose port differs from `cfg_port` produces no event and does not change `drop_count`.
- R3: Within an accepted frame, every four bytes form one word, and the first byte of the four is bits 31:24.
- R4: The table index is word bits 21:16 (the low bits of the source identifier). Word bits 31:22 and 15:14 have no effect on the result.
- R5: A word whose entry is valid, and whose neuron number (bits 13:0) is below that entry's limit, produces one event with `ev_addr` = (base + neuron number) mod 2^14. The event appears on the cycle after the word's last byte is taken.
- R6: A word whose entry is invalid, or whose neuron number is greater than or equal to the limit, produces no event and increments `drop_count` by one.
- R7: Trailing bytes that do not fill a word at the end of a frame are discarded without an event or a count. The next frame starts on a word boundary.
- R8: Only the first MAX_WORDS (256) complete words of a frame are translated. Each later complete word in that frame is dropped and counted.
- R9: While `ev_valid` is 1 and `ev_ready` is 0, `ev_addr` holds its value, `ev_valid` stays 1, and `in_ready` is 0.
- R10: A table write applies to every word whose last byte is taken on a later cycle. Rewriting an entry replaces its validity, base and limit.
- R11: `drop_count` stops at its maximum value (2^DROP_W - 1) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_port | input | PORT_W | Port number whose frames are accepted |
| in_valid | input | 1 | Payload byte present |
| in_ready | output | 1 | Byte taken when high with in_valid |
| in_data | input | 8 | Payload byte |
| in_dport | input | PORT_W | Destination port of the current frame |
| in_last | input | 1 | Final byte of the frame |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W | Entry to write |
| tbl_vld | input | 1 | Valid bit written to the entry |
| tbl_base | input | 14 | Base address written to the entry |
| tbl_limit | input | 14 | Neuron-count limit written to the entry |
| ev_valid | output | 1 | Spike event present |
| ev_ready | input | 1 | Consumer accepts the event |
| ev_addr | output | 14 | Translated local target address |
| drop_count | output | DROP_W | Saturating count of rejected words |

## Verification
The assertions check four things on every cycle. A stalled event holds steady. The counter moves by at most one step and only when a byte is taken. The counter sticks once it saturates. An event never appears without an input byte behind it. The bench's scenarios are the only place that shows what the mapping computes: byte order, the table index and the ignored bits, base-plus-neuron wrap, limit and validity rejects, port rejection, partial-word discard, truncation at the word budget, and the effect of rewriting an entry. A behavioural model checks each of these against every handed-off event and against the drop count on every clock.

// File: rtl/udp_spike_mapper.sv
module udp_spike_mapper #(
  parameter int PORT_W    = 16,
  parameter int IDX_W     = 6,
  parameter int MAX_WORDS = 256,
  parameter int DROP_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic [PORT_W-1:0] in_dport,
  input  logic              in_last,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic              tbl_vld,
  input  logic [13:0]       tbl_base,
  input  logic [13:0]       tbl_limit,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [13:0]       ev_addr,
  output logic [DROP_W-1:0] drop_count
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int WCNT_W  = $clog2(MAX_WORDS + 1);
  localparam logic [WCNT_W-1:0] WORD_CAP = WCNT_W'(MAX_WORDS);

  logic              first_q, acc_q;
  logic [1:0]        bcnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [5:0]        nhi_q;
  logic [WCNT_W-1:0] wcnt_q;

  logic              ent_vld [ENTRIES];
  logic [13:0]       ent_base[ENTRIES];
  logic [13:0]       ent_lim [ENTRIES];

  logic              take, port_ok, word_done, room, hit, emit, reject;
  logic [13:0]       nrn;

  assign in_ready  = !ev_valid || ev_ready;
  assign take      = in_valid && in_ready;
  assign port_ok   = first_q ? (in_dport == cfg_port) : acc_q;
  assign word_done = take && port_ok && (bcnt_q == 2'd3);
  assign room      = wcnt_q < WORD_CAP;
  assign nrn       = {nhi_q, in_data};
  assign hit       = ent_vld[idx_q] && (nrn < ent_lim[idx_q]);
  assign emit      = word_done && room && hit;
  assign reject    = word_done && !(room && hit);

  genvar e;
  generate
    for (e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk) begin
        if (!rst_n)
          ent_vld[e] <= 1'b0;
        else if (tbl_we && tbl_idx == IDX_W'(e))
          ent_vld[e] <= tbl_vld;
      end
      always_ff @(posedge clk) begin
        if (tbl_we && tbl_idx == IDX_W'(e)) begin
          ent_base[e] <= tbl_base;
          ent_lim[e]  <= tbl_limit;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      acc_q   <= 1'b0;
      bcnt_q  <= 2'd0;
      idx_q   <= '0;
      nhi_q   <= '0;
      wcnt_q  <= '0;
    end else if (take) begin
      first_q <= in_last;
      if (first_q) acc_q <= (in_dport == cfg_port);
      if (bcnt_q == 2'd1) idx_q <= in_data[IDX_W-1:0];
      if (bcnt_q == 2'd2) nhi_q <= in_data[5:0];
      bcnt_q <= in_last ? 2'd0 : bcnt_q + 2'd1;
      if (in_last)
        wcnt_q <= '0;
      else if (word_done && room)
        wcnt_q <= wcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_addr  <= '0;
    end else if (emit) begin
      ev_valid <= 1'b1;
      ev_addr  <= ent_base[idx_q] + nrn;
    end else if (ev_ready) begin
      ev_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      drop_count <= '0;
    else if (reject && drop_count != '1)
      drop_count <= drop_count + 1'b1;
  end

endmodule

// File: rtl/udp_spike_mapper_sva.sv
module udp_spike_mapper_sva #(
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [13:0]       ev_addr,
  input logic [DROP_W-1:0] drop_count
);

  // R9: a stalled event keeps its value
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_addr)));

  // R5: no new event without a byte taken
  p_out_needs_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && (!ev_valid || ev_ready)) |=> !ev_valid);

  // R6: the counter only moves on a taken byte
  p_drop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(drop_count));

  // R6: at most one drop per cycle
  p_drop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_count == $past(drop_count) || drop_count == $past(drop_count) + 1'b1));

  // R11: saturated counter stays put
  p_drop_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == {DROP_W{1'b1}}) |=> (drop_count == {DROP_W{1'b1}}));

endmodule

bind udp_spike_mapper udp_spike_mapper_sva #(.DROP_W(DROP_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr),
  .drop_count(drop_count)
);

// File: tb/udp_spike_mapper_bench.sv
module udp_spike_mapper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int DMAX = (1 << DW) - 1;
  localparam logic [15:0] CFG = 16'h1F90;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, tbl_we = 0, tbl_vld = 0, ev_ready = 1;
  logic [7:0] in_data = 0;
  logic [15:0] in_dport = 0;
  logic [5:0] tbl_idx = 0;
  logic [13:0] tbl_base = 0, tbl_limit = 0;
  logic in_ready, ev_valid;
  logic [13:0] ev_addr;
  logic [DW-1:0] drop_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  udp_spike_mapper #(.DROP_W(DW)) u_udp_spike_mapper (
    .clk(clk), .rst_n(rst_n), .cfg_port(CFG), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_dport(in_dport), .in_last(in_last), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_vld(tbl_vld), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr), .drop_count(drop_count));

  int checks = 0, errors = 0, n_out = 0, cyc = 0;
  bit stall_mode = 0;
  int exp_q[$];
  logic [7:0] byte_q[$];
  int m_vld[64], m_base[64], m_lim[64];
  int m_drop = 0, m_bytes = 0, m_words = 0;
  bit m_first = 1, m_acc = 0;
  logic [31:0] m_word = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    ev_ready <= stall_mode ? ((cyc % 3) == 0) : 1'b1;
  end

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        chk("R6 R8 R11 drop_count", int'(drop_count), m_drop);
        if (ev_valid && !ev_ready) chk("R9 in_ready low while stalled", int'(in_ready), 0);
        if (ev_valid && ev_ready) begin
          n_out++;
          if (exp_q.size() == 0) chk("R2 R6 unexpected event", 1, 0);
          else chk("R3 R4 R5 ev_addr", int'(ev_addr), exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [31:0] mkw(logic [15:0] src, logic [1:0] pad, logic [13:0] n);
    return {src, pad, n};
  endfunction

  task automatic push_word(logic [31:0] w);
    for (int b = 3; b >= 0; b--) byte_q.push_back(w[b*8 +: 8]);
  endtask

  task automatic model_byte(logic [15:0] port, logic [7:0] d, logic last);
    int i, n;
    if (m_first) m_acc = (port == CFG);
    m_first = last;
    if (m_acc) begin
      m_word = {m_word[23:0], d};
      m_bytes++;
      if (m_bytes == 4) begin
        m_bytes = 0;
        if (m_words >= 256) begin
          if (m_drop < DMAX) m_drop++;
        end else begin
          m_words++;
          i = int'(m_word[21:16]);
          n = int'(m_word[13:0]);
          if (m_vld[i] != 0 && n < m_lim[i]) exp_q.push_back((m_base[i] + n) % 16384);
          else if (m_drop < DMAX) m_drop++;
        end
      end
    end
    if (last) begin
      m_bytes = 0;
      m_words = 0;
    end
  endtask

  task automatic send_byte(logic [15:0] port, logic [7:0] d, logic last);
    bit hs;
    @(negedge clk);
    in_valid = 1; in_data = d; in_dport = port; in_last = last;
    do begin
      #1 hs = in_ready;
      @(posedge clk);
      if (!hs) @(negedge clk);
    end while (!hs);
    model_byte(port, d, last);
  endtask

  task automatic send_frame(logic [15:0] port);
    int n = byte_q.size();
    for (int k = 0; k < n; k++) send_byte(port, byte_q[k], k == n - 1);
    byte_q.delete();
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic tbl_write(int idx, bit v, int base, int lim);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 6'(idx); tbl_vld = v; tbl_base = 14'(base); tbl_limit = 14'(lim);
    @(posedge clk);
    m_vld[idx] = v; m_base[idx] = base; m_lim[idx] = lim;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic drain;
    for (int k = 0; k < 100 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int o0, d0;
    for (int k = 0; k < 64; k++) begin m_vld[k] = 0; m_base[k] = 0; m_lim[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #2;
    chk("R1 ev_valid after reset", int'(ev_valid), 0);
    chk("R1 drop_count after reset", int'(drop_count), 0);
    chk("R1 in_ready after reset", int'(in_ready), 1);

    // R1/R6: empty table drops everything
    o0 = n_out;
    push_word(mkw(16'h0005, 2'b00, 14'd3));
    push_word(mkw(16'h0000, 2'b00, 14'd0));
    send_frame(CFG); drain;
    chk("R1 no events from empty table", n_out - o0, 0);
    chk("R1 R6 drops from empty table", int'(drop_count), 2);

    // R3 R4 R5 R6
    tbl_write(5, 1, 100, 50);
    tbl_write(6, 1, 16380, 20);
    o0 = n_out;
    push_word(mkw(16'h0005, 2'b00, 14'd3));
    push_word(mkw(16'hFFC5, 2'b11, 14'd49));
    push_word(mkw(16'h0005, 2'b00, 14'd50));
    push_word(mkw(16'h0006, 2'b00, 14'd10));
    send_frame(CFG); drain;
    chk("R5 R4 events from mapped words", n_out - o0, 3);
    chk("R6 limit reject counted", int'(drop_count), 3);

    // R2 wrong port, then right port
    o0 = n_out; d0 = int'(drop_count);
    push_word(mkw(16'h0005, 2'b00, 14'd1));
    push_word(mkw(16'h0005, 2'b00, 14'd2));
    push_word(mkw(16'h0007, 2'b00, 14'd2));
    send_frame(CFG + 16'd1); drain;
    chk("R2 no events on other port", n_out - o0, 0);
    chk("R2 no drops on other port", int'(drop_count) - d0, 0);
    push_word(mkw(16'h0005, 2'b00, 14'd4));
    send_frame(CFG); drain;
    chk("R2 accepted after rejected frame", n_out - o0, 1);

    // R7 partial trailing word
    o0 = n_out; d0 = int'(drop_count);
    push_word(mkw(16'h0005, 2'b00, 14'd5));
    byte_q.push_back(8'h00); byte_q.push_back(8'h05);
    send_frame(CFG);
    push_word(mkw(16'h0005, 2'b00, 14'd6));
    send_frame(CFG); drain;
    chk("R7 whole words only", n_out - o0, 2);
    chk("R7 partial not counted", int'(drop_count) - d0, 0);

    // R9 backpressure
    stall_mode = 1;
    o0 = n_out;
    for (int k = 0; k < 12; k++) push_word(mkw(16'h0005, 2'b00, 14'(k)));
    send_frame(CFG); drain;
    chk("R9 all events under stall", n_out - o0, 12);
    stall_mode = 0;
    drain;

    // R10 rewrite entry
    o0 = n_out;
    tbl_write(5, 0, 100, 50);
    push_word(mkw(16'h0005, 2'b00, 14'd0));
    send_frame(CFG); drain;
    chk("R10 invalidated entry drops", n_out - o0, 0);
    tbl_write(5, 1, 7, 1);
    push_word(mkw(16'h0005, 2'b00, 14'd0));
    push_word(mkw(16'h0005, 2'b00, 14'd1));
    send_frame(CFG); drain;
    chk("R10 new entry used", n_out - o0, 1);
    chk("R10 R6 drops after rewrite", int'(drop_count), 5);

    // R8 truncation
    o0 = n_out;
    for (int k = 0; k < 260; k++) push_word(mkw(16'h0005, 2'b00, 14'd0));
    send_frame(CFG); drain;
    chk("R8 events capped at 256", n_out - o0, 256);
    chk("R8 truncated words counted", int'(drop_count), 9);

    // R11 saturation
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < 130; k++) push_word(mkw(16'h003F, 2'b00, 14'd1));
      send_frame(CFG);
    end
    drain;
    chk("R11 counter saturated", int'(drop_count), DMAX);
    chk("R5 expected queue empty", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule